// File: doc/BRIEF.md
# Cycle/strobe master to active-low strobe slave bridge

This block joins two on-chip bus ports that share one clock. The master side follows the Wishbone classic handshake: a cycle flag marks an open bus cycle, a strobe marks a live transfer inside it, a write flag chooses the direction, and a done flag closes the transfer. The slave side is a memory-mapped port that takes a select line, separate active-low read and write strobes, and a stall input. The bridge maps one handshake onto the other without storage on the transfer path. A slave that never stalls therefore completes every transfer in the cycle the master presents it.

Back-pressure comes only from the slave. While the slave raises its stall input, the master sees done low and must hold its request and data steady. The transfer completes in the first cycle in which stall is low. Address, write data, byte enables and read data pass through unchanged at a width fixed by a parameter. A one-bit run flag, cleared by the synchronous reset, keeps both slave strobes and the done flag inactive during reset and for the rest of the cycle in which reset is released.

Top module: `wbav_bridge`

## Requirements
- R1: The data width parameter DW accepts only 8, 16, 32 or 64. The byte enable bus has DW/8 bits.
- R2: The slave select output equals the master strobe input in the same cycle, whatever the state of cycle, write or reset.
- R3: Once the bridge is running, the active-low write strobe is 0 exactly when cycle and write are both 1. Strobe has no effect on it.
- R4: Once the bridge is running, the active-low read strobe is 0 exactly when cycle is 1 and write is 0.
- R5: The read and write strobes are never 0 together. Both are 1 while reset is 1 and until the first clock edge at which reset is sampled 0.
- R6: Once the bridge is running, done is 1 exactly when cycle, strobe and NOT stall are all 1, with no register in the path. A transfer that meets a slave which does not stall completes in its first cycle.
- R7: Done stays 0 whenever cycle or strobe is 0, even when stall is 0.
- R8: While stall is 1, done stays 0 for every such cycle. It rises in the first cycle in which stall falls, provided the request is still held.
- R9: Address, write data and byte enables reach the slave unchanged. Byte enable bit i covers data bits 8i+7 down to 8i.
- R10: Slave read data reaches the master read data output unchanged and combinationally, so it is valid in the cycle in which done is 1.

Each bit of the write and read strobes above is active low: 0 means asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous reset, active high |
| m_cycle | input | 1 | Master: bus cycle open |
| m_strobe | input | 1 | Master: transfer requested |
| m_wr | input | 1 | Master: 1 = write, 0 = read |
| m_addr | input | AW | Master address |
| m_wdata | input | DW | Master write data |
| m_bsel | input | DW/8 | Master byte selects |
| m_rdata | output | DW | Read data returned to master |
| m_done | output | 1 | Transfer complete |
| s_sel | output | 1 | Slave select |
| s_wr_l | output | 1 | Slave write strobe, active low |
| s_rd_l | output | 1 | Slave read strobe, active low |
| s_addr | output | AW | Slave address |
| s_wdata | output | DW | Slave write data |
| s_ben | output | DW/8 | Slave byte enables |
| s_rdata | input | DW | Slave read data |
| s_stall | input | 1 | Slave stall, 1 = wait |

## Verification
The hardest case to reach from the ports is the single partial cycle between the release of reset and the next clock edge. The run flag is still clear there, so a request that is already on the master port must not reach the slave. To hit it, the bench drives a full write request while reset is still high. It drops reset at a falling edge and samples the strobes and done before and after the next rising edge. A second case that needs care is a stall held for several cycles. Done must stay low through every stalled cycle and rise in the exact cycle stall drops, and the bench checks each of those cycles in turn.

// File: rtl/wbav_pkg.sv
package wbav_pkg;
  localparam int LANE_W = 8;

  function automatic bit width_ok(input int w);
    return (w == 8) || (w == 16) || (w == 32) || (w == 64);
  endfunction

  function automatic int lanes_of(input int w);
    return w / LANE_W;
  endfunction
endpackage

// File: rtl/wbav_ctl.sv
module wbav_ctl (
  input  logic clk,
  input  logic rst,
  input  logic m_cycle,
  input  logic m_strobe,
  input  logic m_wr,
  input  logic s_stall,
  output logic s_sel,
  output logic s_wr_l,
  output logic s_rd_l,
  output logic m_done
);
  logic run_q;
  logic live;

  // Run flag: clear in reset, set at the first edge with reset low.
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  always_comb begin
    live   = run_q & ~rst;
    s_sel  = m_strobe;
    s_wr_l = ~(live & m_cycle & m_wr);
    s_rd_l = ~(live & m_cycle & ~m_wr);
    m_done = live & m_cycle & m_strobe & ~s_stall;
  end
endmodule

// File: rtl/wbav_lanes.sv
module wbav_lanes #(
  parameter int DW = 32,
  localparam int NL = wbav_pkg::lanes_of(DW)
) (
  input  logic [DW-1:0] m_wdata,
  input  logic [NL-1:0] m_bsel,
  input  logic [DW-1:0] s_rdata,
  output logic [DW-1:0] s_wdata,
  output logic [NL-1:0] s_ben,
  output logic [DW-1:0] m_rdata
);
  localparam int LW = wbav_pkg::LANE_W;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign s_wdata[g*LW +: LW] = m_wdata[g*LW +: LW];
    assign m_rdata[g*LW +: LW] = s_rdata[g*LW +: LW];
    assign s_ben[g]            = m_bsel[g];
  end
endmodule

// File: rtl/wbav_bridge.sv
module wbav_bridge #(
  parameter int DW = 32,
  parameter int AW = 32,
  localparam int NL = wbav_pkg::lanes_of(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m_cycle,
  input  logic          m_strobe,
  input  logic          m_wr,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  input  logic [NL-1:0] m_bsel,
  output logic [DW-1:0] m_rdata,
  output logic          m_done,
  output logic          s_sel,
  output logic          s_wr_l,
  output logic          s_rd_l,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_wdata,
  output logic [NL-1:0] s_ben,
  input  logic [DW-1:0] s_rdata,
  input  logic          s_stall
);
  // R1: only the four legal widths elaborate.
  if (!wbav_pkg::width_ok(DW)) begin : g_bad_dw
    $error("wbav_bridge: DW must be 8, 16, 32 or 64");
  end

  wbav_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .m_cycle  (m_cycle),
    .m_strobe (m_strobe),
    .m_wr     (m_wr),
    .s_stall  (s_stall),
    .s_sel    (s_sel),
    .s_wr_l   (s_wr_l),
    .s_rd_l   (s_rd_l),
    .m_done   (m_done)
  );

  wbav_lanes #(.DW(DW)) u_lanes (
    .m_wdata (m_wdata),
    .m_bsel  (m_bsel),
    .s_rdata (s_rdata),
    .s_wdata (s_wdata),
    .s_ben   (s_ben),
    .m_rdata (m_rdata)
  );

  assign s_addr = m_addr;
endmodule

// File: rtl/wbav_bridge_chk.sv
module wbav_bridge_chk #(
  parameter int DW = 32,
  parameter int AW = 32,
  localparam int NL = DW / 8
) (
  input logic          clk,
  input logic          rst,
  input logic          m_cycle,
  input logic          m_strobe,
  input logic          m_wr,
  input logic [AW-1:0] m_addr,
  input logic [DW-1:0] m_wdata,
  input logic [NL-1:0] m_bsel,
  input logic [DW-1:0] m_rdata,
  input logic          m_done,
  input logic          s_sel,
  input logic          s_wr_l,
  input logic          s_rd_l,
  input logic [AW-1:0] s_addr,
  input logic [DW-1:0] s_wdata,
  input logic [NL-1:0] s_ben,
  input logic [DW-1:0] s_rdata,
  input logic          s_stall
);
  a_r2_sel_follows: assert property (@(posedge clk) s_sel == m_strobe);

  a_r3_wr_needs_cyc: assert property (@(posedge clk) disable iff (rst)
    !s_wr_l |-> (m_cycle && m_wr));

  a_r4_rd_needs_cyc: assert property (@(posedge clk) disable iff (rst)
    !s_rd_l |-> (m_cycle && !m_wr));

  a_r5_exclusive: assert property (@(posedge clk)
    !(!s_wr_l && !s_rd_l));

  a_r5_quiet_in_reset: assert property (@(posedge clk)
    rst |-> (s_wr_l && s_rd_l && !m_done));

  a_r5_quiet_after_release: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (s_wr_l && s_rd_l && !m_done));

  a_r6_done_not_stalled: assert property (@(posedge clk) disable iff (rst)
    m_done |-> !s_stall);

  a_r7_done_needs_req: assert property (@(posedge clk) disable iff (rst)
    m_done |-> (m_cycle && m_strobe));

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    s_stall |-> !m_done);

  a_r9_pass_down: assert property (@(posedge clk) disable iff (rst)
    (s_addr == m_addr) && (s_wdata == m_wdata) && (s_ben == m_bsel));

  a_r10_pass_up: assert property (@(posedge clk) disable iff (rst)
    m_done |-> (m_rdata == s_rdata));
endmodule

bind wbav_bridge wbav_bridge_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/wbav_bridge_tb.sv
module wbav_bridge_tb;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int NL = DW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          m_cycle = 1'b0, m_strobe = 1'b0, m_wr = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  logic [NL-1:0] m_bsel = '0;
  logic [DW-1:0] m_rdata;
  logic          m_done, s_sel, s_wr_l, s_rd_l;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  logic [NL-1:0] s_ben;
  logic [DW-1:0] s_rdata = '0;
  logic          s_stall = 1'b0;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  wbav_bridge #(.DW(DW), .AW(AW)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns later (combinational outputs).
  task automatic drive(input logic cyc, input logic stb, input logic wr, input logic stall);
    @(negedge clk);
    m_cycle = cyc; m_strobe = stb; m_wr = wr; s_stall = stall;
    #1;
  endtask

  task automatic t_reset_release();
    m_cycle = 1; m_strobe = 1; m_wr = 1; s_stall = 0;
    #1;
    chk("R5 wr strobe off in reset", s_wr_l, 1);
    chk("R5 rd strobe off in reset", s_rd_l, 1);
    chk("R5 done off in reset", m_done, 0);
    chk("R2 select in reset", s_sel, 1);
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    chk("R5 wr off before first run edge", s_wr_l, 1);
    chk("R5 done off before first run edge", m_done, 0);
    @(negedge clk); #1;
    chk("R3 wr strobe after release", s_wr_l, 0);
    chk("R6 done after release", m_done, 1);
  endtask

  task automatic t_zero_wait();
    m_addr = 32'h0000_1A40; m_wdata = 32'hCAFE_0123; m_bsel = 4'b1010;
    drive(1, 1, 1, 0);
    chk("R3 write strobe", s_wr_l, 0);
    chk("R4 read strobe idle on write", s_rd_l, 1);
    chk("R6 write done same cycle", m_done, 1);
    chk("R9 address", s_addr, 32'h0000_1A40);
    chk("R9 write data", s_wdata, 32'hCAFE_0123);
    chk("R9 byte enables", s_ben, 4'b1010);
    s_rdata = 32'h5A5A_C3C3;
    drive(1, 1, 0, 0);
    chk("R4 read strobe", s_rd_l, 0);
    chk("R3 write strobe idle on read", s_wr_l, 1);
    chk("R6 read done same cycle", m_done, 1);
    chk("R10 read data", m_rdata, 32'h5A5A_C3C3);
  endtask

  task automatic t_no_request();
    drive(0, 0, 1, 0);
    chk("R7 done idle", m_done, 0);
    chk("R3 wr idle no cycle", s_wr_l, 1);
    chk("R2 select low", s_sel, 0);
    drive(1, 0, 1, 0);
    chk("R7 done with cycle only", m_done, 0);
    chk("R3 wr follows cycle not strobe", s_wr_l, 0);
    chk("R2 select low cycle only", s_sel, 0);
    drive(0, 1, 0, 0);
    chk("R7 done with strobe only", m_done, 0);
    chk("R4 rd idle no cycle", s_rd_l, 1);
    chk("R2 select strobe only", s_sel, 1);
  endtask

  task automatic t_stall();
    s_rdata = 32'h0BAD_F00D;
    for (int i = 0; i < 3; i++) begin
      drive(1, 1, 0, 1);
      chk("R8 done held while stalled", m_done, 0);
      chk("R4 read strobe held while stalled", s_rd_l, 0);
    end
    drive(1, 1, 0, 0);
    chk("R8 done when stall drops", m_done, 1);
    chk("R10 read data at done", m_rdata, 32'h0BAD_F00D);
  endtask

  task automatic t_lanes();
    m_bsel = 4'b0001; m_wdata = 32'hFFFF_FF00; s_rdata = 32'h1234_5678;
    drive(1, 1, 1, 0);
    chk("R1 byte enable width", $bits(s_ben), NL);
    chk("R9 single lane enable", s_ben, 4'b0001);
    chk("R9 lane data", s_wdata, 32'hFFFF_FF00);
    chk("R10 read lanes", m_rdata, 32'h1234_5678);
    drive(0, 0, 0, 0);
  endtask

  initial begin
    t_reset_release();
    t_zero_wait();
    t_no_request();
    t_stall();
    t_lanes();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule